// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup and Replacement Unit

This block holds the tag, valid flag and one data word for every way of a small two-way set-associative cache. A block address is split into a set index, taken from its low bits so that the set is the block number modulo the number of sets, and a tag made of the remaining high bits. Both ways of the addressed set are compared at once. In the same cycle the unit reports hit, the way that hit and that way's data.

After a miss, the surrounding controller fetches the block from the next level and presents it on the fill port. The unit returns the way it will write. That is the way already holding the block if it is resident, otherwise an empty way, otherwise the least recently used way. The block is written at the clock edge. Each set keeps one recency bit. It points at the way not touched most recently, and it is updated on every lookup hit and every fill.

Top module: `cache2w_lru`

## Requirements
- R1: A synchronous reset clears every valid flag and every recency bit. After reset every lookup misses, and the first fill into any set selects way 0.
- R2: The set index is the low log2(SETS) bits of the block address (block number modulo SETS) and the tag is the remaining high bits. Two addresses in the same set with different tags never hit on each other.
- R3: A lookup compares both ways of its set in the same cycle. `lk_hit` is 1 when a valid way holds the tag, `lk_way` gives that way (0 or 1) and `lk_data` its word. On a miss, `lk_way` and `lk_data` are 0, and a block is never held in both ways of a set.
- R4: For a fill of a non-resident block, an invalid way is chosen if one exists, with way 0 chosen before way 1.
- R5: When both ways of the set are valid, a fill of a non-resident block replaces the way named by the set's recency bit, which is the least recently used way.
- R6: A lookup hit (with no fill in that cycle) sets the set's recency bit to the way that did not hit. A lookup miss leaves it unchanged.
- R7: A fill writes tag, data and valid into the way shown on `fl_way`, and sets the recency bit to the other way. The new block hits from the next cycle.
- R8: A fill of a block already resident rewrites the data in its own way and does not create a second copy.
- R9: When a lookup and a fill occur in the same cycle, only the fill updates recency. The lookup's own hit result is still reported.
- R10: With two sets of two ways, the block sequence 0, 8, 0, 6, 8 (each miss followed by a fill) gives miss, miss, hit, miss, miss. Block 6 replaces 8, and then 8 replaces 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_en | input | 1 | Lookup strobe; a hit updates recency |
| lk_addr | input | ADDR_W | Lookup block address |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 1 | Way that hit (0 on miss) |
| lk_data | output | DATA_W | Data of the hitting way (0 on miss) |
| fl_en | input | 1 | Fill strobe; write happens at the clock edge |
| fl_addr | input | ADDR_W | Fill block address |
| fl_data | input | DATA_W | Fill data word |
| fl_way | output | 1 | Way the fill writes (resident, invalid or LRU) |

## Verification
The directed part runs the five-access conflict sequence inside a single set. It tells true LRU apart from a direct-mapped or FIFO choice: the third access must hit and the last must evict block 0. Lookups after reset and after a mid-run reset show that valid and recency state are cleared. A refill of a resident block shows that the resident way wins over the victim rule. A random mix of lookups, fills and same-cycle lookup-plus-fill on a small address space keeps both ways of each set full. This exercises LRU replacement, hit-driven recency changes and fill-over-lookup priority against a bench model.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic {
        WAY0 = 1'b0,
        WAY1 = 1'b1
    } way_e;

    // Replacement choice for a non-resident block: empty way first, then LRU.
    function automatic way_e pick_victim(input logic v0, input logic v1, input logic lru);
        if (!v0)      return WAY0;
        else if (!v1) return WAY1;
        else          return way_e'(lru);
    endfunction

endpackage

// File: rtl/cache_way.sv
module cache_way #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [SET_W-1:0]  fl_set,
    input  logic [TAG_W-1:0]  fl_tag,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              lk_match,
    output logic [DATA_W-1:0] lk_rdata,
    output logic              fl_match,
    output logic [SETS-1:0]   vld_vec
);

    typedef struct packed {
        logic [SETS-1:0]             vld;
        logic [SETS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][DATA_W-1:0] dat;
    } way_st_t;

    way_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[fl_set] = 1'b1;
            st_d.tag[fl_set] = fl_tag;
            st_d.dat[fl_set] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lk_match = st_q.vld[lk_set] && (st_q.tag[lk_set] == lk_tag);
    assign lk_rdata = st_q.dat[lk_set];
    assign fl_match = st_q.vld[fl_set] && (st_q.tag[fl_set] == fl_tag);
    assign vld_vec  = st_q.vld;

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
    parameter int SETS = 4,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic             touch_way,
    output logic [SETS-1:0]  lru_vec
);

    logic [SETS-1:0] lru_d, lru_q;

    always_comb begin
        lru_d = lru_q;
        if (touch_en) lru_d[touch_set] = ~touch_way;
    end

    always_ff @(posedge clk) begin
        if (rst) lru_q <= '0;
        else     lru_q <= lru_d;
    end

    assign lru_vec = lru_q;

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_way,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fl_en,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_data,
    output logic              fl_way
);

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int NWAYS = 2;

    logic [SET_W-1:0]  lk_set, fl_set;
    logic [TAG_W-1:0]  lk_tag, fl_tag;
    logic [NWAYS-1:0]  lk_m, fl_m;
    logic [DATA_W-1:0] rdat [NWAYS];
    logic [SETS-1:0]   vld  [NWAYS];
    logic [SETS-1:0]   lru_vec;
    way_e              lk_way_e, fl_way_e;
    logic              touch_en, touch_way;
    logic [SET_W-1:0]  touch_set;

    assign lk_set = lk_addr[SET_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:SET_W];
    assign fl_set = fl_addr[SET_W-1:0];
    assign fl_tag = fl_addr[ADDR_W-1:SET_W];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        cache_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
            .clk      (clk),
            .rst      (rst),
            .lk_set   (lk_set),
            .lk_tag   (lk_tag),
            .fl_set   (fl_set),
            .fl_tag   (fl_tag),
            .wr_en    (fl_en && (fl_way_e == way_e'(w))),
            .wr_data  (fl_data),
            .lk_match (lk_m[w]),
            .lk_rdata (rdat[w]),
            .fl_match (fl_m[w]),
            .vld_vec  (vld[w])
        );
    end

    always_comb begin
        lk_hit   = |lk_m;
        lk_way_e = lk_m[1] ? WAY1 : WAY0;
        lk_data  = (lk_m[0] ? rdat[0] : '0) | (lk_m[1] ? rdat[1] : '0);
        if (|fl_m) fl_way_e = fl_m[1] ? WAY1 : WAY0;
        else       fl_way_e = pick_victim(vld[0][fl_set], vld[1][fl_set], lru_vec[fl_set]);
        touch_en  = fl_en || (lk_en && lk_hit);
        touch_set = fl_en ? fl_set : lk_set;
        touch_way = fl_en ? fl_way_e : lk_way_e;
    end

    assign lk_way = lk_way_e;
    assign fl_way = fl_way_e;

    cache_lru #(.SETS(SETS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_set (touch_set),
        .touch_way (touch_way),
        .lru_vec   (lru_vec)
    );

    // R1: reset leaves no valid entry and no recency state
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (vld[0] == '0) && (vld[1] == '0) && (lru_vec == '0));

    // R3: the two way comparators never both match
    a_r3_single_hit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_m));

    // R7: the way just filled is valid in the next cycle
    a_r7_fill_valid: assert property (@(posedge clk) disable iff (rst)
        fl_en |=> vld[$past(fl_way)][$past(fl_set)]);

    // R7: after a fill, recency points away from the filled way
    a_r7_lru_fill: assert property (@(posedge clk) disable iff (rst)
        fl_en |=> lru_vec[$past(fl_set)] != $past(fl_way));

    // R6: a lookup hit without a fill makes the other way least recent
    a_r6_lru_hit: assert property (@(posedge clk) disable iff (rst)
        (lk_en && lk_hit && !fl_en) |=> lru_vec[$past(lk_set)] != $past(lk_way));

    // R6: a lookup miss without a fill keeps all recency bits
    a_r6_miss_keeps: assert property (@(posedge clk) disable iff (rst)
        (!fl_en && !(lk_en && lk_hit)) |=> $stable(lru_vec));

endmodule

// File: tb/tb_cache2w_lru.sv
module tb_cache2w_lru;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int S  = 2;
    localparam int SW = $clog2(S);

    logic          clk = 0;
    logic          rst = 1;
    logic          lk_en = 0, fl_en = 0;
    logic [AW-1:0] lk_addr = '0, fl_addr = '0;
    logic [DW-1:0] fl_data = '0;
    logic          lk_hit, lk_way, fl_way;
    logic [DW-1:0] lk_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    bit            m_vld [2][S];
    bit [AW-1:0]   m_adr [2][S];
    bit [DW-1:0]   m_dat [2][S];
    bit            m_lru [S];

    always #4 clk = ~clk;

    cache2w_lru #(.ADDR_W(AW), .DATA_W(DW), .SETS(S)) dut (
        .clk(clk), .rst(rst), .lk_en(lk_en), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_way(lk_way), .lk_data(lk_data), .fl_en(fl_en), .fl_addr(fl_addr),
        .fl_data(fl_data), .fl_way(fl_way)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int set_of(input logic [AW-1:0] a);
        return int'(a % S);
    endfunction

    // returns -1 on miss, else way
    function automatic int m_find(input logic [AW-1:0] a);
        int s = set_of(a);
        for (int w = 0; w < 2; w++)
            if (m_vld[w][s] && m_adr[w][s] == a) return w;
        return -1;
    endfunction

    function automatic int m_victim(input logic [AW-1:0] a);
        int s = set_of(a);
        int f = m_find(a);
        if (f >= 0) return f;
        if (!m_vld[0][s]) return 0;
        if (!m_vld[1][s]) return 1;
        return int'(m_lru[s]);
    endfunction

    task automatic m_clear();
        for (int s = 0; s < S; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_vld[w][s] = 0; m_adr[w][s] = '0; m_dat[w][s] = '0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        m_clear();
    endtask

    task automatic check_lk(input string req);
        int f = m_find(lk_addr);
        chk(lk_hit == (f >= 0), req, lk_hit, f >= 0);
        if (f >= 0) begin
            chk(lk_way == f[0], req, lk_way, f);
            chk(lk_data == m_dat[f][set_of(lk_addr)], req, lk_data, m_dat[f][set_of(lk_addr)]);
        end else begin
            chk(lk_way == 1'b0 && lk_data == '0, req, {lk_way, lk_data}, 0);
        end
    endtask

    // lk/fl select which ports are driven in this cycle; returns lookup hit
    task automatic do_op(input bit lk, input bit fl, input logic [AW-1:0] la,
                         input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                         input string req, output bit hit);
        int lf, vw;
        @(negedge clk);
        lk_en = lk; lk_addr = la; fl_en = fl; fl_addr = fa; fl_data = fd;
        #1;
        lf = m_find(la);
        hit = (lf >= 0);
        vw = m_victim(fa);
        if (lk) check_lk(req);
        if (fl) chk(fl_way == vw[0], req, fl_way, vw);
        @(posedge clk);
        if (fl) begin
            m_vld[vw][set_of(fa)] = 1; m_adr[vw][set_of(fa)] = fa;
            m_dat[vw][set_of(fa)] = fd; m_lru[set_of(fa)] = ~vw[0];
        end else if (lk && lf >= 0) begin
            m_lru[set_of(la)] = ~lf[0];
        end
        #1; lk_en = 0; fl_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit h;
        int seq [5] = '{0, 8, 0, 6, 8};
        bit exp_h [5] = '{0, 0, 1, 0, 0};
        void'($urandom(32'd2024));
        m_clear();
        repeat (2) @(negedge clk);
        rst = 0;

        // R1: everything misses after reset, first fill picks way 0
        for (int a = 0; a < 8; a++) do_op(1, 0, a[AW-1:0], '0, '0, "R1", h);
        do_op(0, 1, '0, 6'd5, 16'h1111, "R1", h);

        // R10: conflict sequence inside one set
        do_reset();
        for (int i = 0; i < 5; i++) begin
            do_op(1, 0, seq[i][AW-1:0], '0, '0, "R10", h);
            chk(h == exp_h[i], "R10", h, exp_h[i]);
            if (!h) do_op(0, 1, '0, seq[i][AW-1:0], DW'(16'hA000 + i), "R10 R5", h);
        end
        do_op(1, 0, 6'd0, '0, '0, "R10", h);
        chk(h == 0, "R10", h, 0);
        do_op(1, 0, 6'd6, '0, '0, "R10", h);
        chk(h == 1, "R10", h, 1);

        // R8: refill of resident block 6 stays in its way
        do_op(0, 1, '0, 6'd6, 16'hBEEF, "R8", h);
        do_op(1, 0, 6'd6, '0, '0, "R8", h);

        // R2: 1 and 3 share set 1 but differ in tag; 2 goes to set 0
        do_reset();
        do_op(0, 1, '0, 6'd1, 16'h0001, "R2", h);
        do_op(1, 0, 6'd3, '0, '0, "R2", h);
        chk(h == 0, "R2", h, 0);
        do_op(0, 1, '0, 6'd3, 16'h0003, "R2 R4", h);
        do_op(0, 1, '0, 6'd2, 16'h0002, "R2 R4", h);

        // R6 then R9: hit on way 0 makes way 1 LRU; same-cycle fill overrides
        do_op(1, 0, 6'd1, '0, '0, "R6", h);
        do_op(0, 1, '0, 6'd5, 16'h0005, "R5 R6", h);
        do_op(1, 1, 6'd5, 6'd3, 16'h0333, "R9", h);
        do_op(0, 1, '0, 6'd7, 16'h0007, "R9", h);

        // R3 R5 R6 R7 R8 R9: random mix on a small address space
        for (int i = 0; i < 1500; i++) begin
            int op = int'($urandom % 4);
            logic [AW-1:0] a1 = AW'($urandom % 12);
            logic [AW-1:0] a2 = AW'($urandom % 12);
            logic [DW-1:0] d  = DW'($urandom);
            case (op)
                0, 1: do_op(1, 0, a1, '0, '0, "R3 R6", h);
                2:    do_op(0, 1, '0, a2, d, "R5 R7 R8", h);
                default: do_op(1, 1, a1, a2, d, "R9", h);
            endcase
        end

        // R1: mid-run reset clears state
        do_reset();
        for (int a = 0; a < 12; a++) do_op(1, 0, a[AW-1:0], '0, '0, "R1", h);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule